// File: doc/BRIEF.md
# Fence-Ordered Store Buffer with Load Retirement Gate

This block sits beside one core of a multiprocessor that follows total store order. Stores that have left the pipeline enter a small in-order buffer, and the buffer sends them to memory one at a time over a valid/ready handshake. The pipeline also sends fence markers and, for every load that completes, its address and a tag. A load that no fence separates from the buffered stores may pass them and is released at once. A load issued after a fence may already hold its data, but it stays speculative until every store accepted before that fence has left the buffer. Only then does the block release it on the retire output.

Each load entry holds a countdown of the pre-fence stores still ahead of it. The countdown is taken when the load is accepted and drops by one on each memory handshake. While the countdown is nonzero, an invalidation from the coherence side that hits the load's address flags the entry. The block then reports the entry's tag on the squash output so that the pipeline can retry the load, and the entry never retires. When the load table is full, the block raises a stall signal towards load issue.

Top module: `fence_wb_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, the store buffer and the load table are empty. mem_valid, ret_valid, sq_valid and lt_full are 0, and st_ready and drained are 1.
- R2: Buffered stores leave in the order they were accepted, at most one per cycle. mem_valid is 1 whenever the buffer is not empty. mem_addr and mem_data show the oldest store and stay unchanged until mem_ready is seen with mem_valid.
- R3: A store is taken when st_valid and st_ready are both 1. st_ready is 0 exactly when SB_DEPTH stores are held, and drained is 1 exactly when none are held.
- R4: Within one cycle the program order is store, then fence, then load. The stores ahead of a fence are every store held once that cycle's store and drain have taken effect. A load is bound to the latest fence accepted in its own cycle or earlier.
- R5: If no pre-fence store of a load's latest fence remains in the buffer after its acceptance cycle (countdown 0), the load may pass the buffered stores. It is offered on ret_valid/ret_tag from the next cycle.
- R6: A load with a nonzero countdown is not offered on ret_valid before the cycle that follows the memory handshake of its last pre-fence store.
- R7: If inv_valid is 1 and inv_addr equals the address of an entry whose countdown is nonzero in that cycle, that entry is marked for squash. This includes a load accepted in the same cycle with a nonzero countdown. A marked entry is reported on sq_valid/sq_tag, is then freed, and never retires.
- R8: A load is accepted when ld_valid is 1 and lt_full is 0. lt_full is 1 exactly when LT_DEPTH entries are held.
- R9: At most one load retires and at most one is squashed per cycle. Other eligible entries wait, and a retire and a squash in the same cycle carry different tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Retired store presented |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_ready | output | 1 | Buffer has room for a store |
| mem_valid | output | 1 | Oldest store offered to memory |
| mem_addr | output | AW | Address of the oldest store |
| mem_data | output | DW | Data of the oldest store |
| mem_ready | input | 1 | Memory takes the offered store |
| fence_valid | input | 1 | Fence marker |
| ld_valid | input | 1 | Completed load presented |
| ld_addr | input | AW | Load address |
| ld_tag | input | TW | Load tag |
| lt_full | output | 1 | Load table full, stall load issue |
| inv_valid | input | 1 | Coherence invalidation |
| inv_addr | input | AW | Invalidated address |
| ret_valid | output | 1 | A load may retire |
| ret_tag | output | TW | Tag of the retiring load |
| sq_valid | output | 1 | A load is squashed |
| sq_tag | output | TW | Tag of the squashed load |
| drained | output | 1 | Store buffer empty |

## Verification
The assertions assume that the tags of loads held together in the table are all distinct, so that a retire and a squash in one cycle can be told apart by tag. They also assume that the pipeline presents a load only while lt_full is low, or accepts that a load offered during lt_full is dropped. The stimulus hands out tags from a rolling counter whose period is far longer than the table depth. It draws load and invalidation addresses from a four-value range so that invalidations hit pending loads often. It holds memory back for long stretches so that fences find stores still ahead of them.

// File: rtl/fence_wb_ctrl.sv
module fence_wb_ctrl #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int TW = 4,
  parameter int SB_DEPTH = 4,
  parameter int LT_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          st_ready,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_ready,
  input  logic          fence_valid,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [TW-1:0] ld_tag,
  output logic          lt_full,
  input  logic          inv_valid,
  input  logic [AW-1:0] inv_addr,
  output logic          ret_valid,
  output logic [TW-1:0] ret_tag,
  output logic          sq_valid,
  output logic [TW-1:0] sq_tag,
  output logic          drained
);
  localparam int PW = (SB_DEPTH > 1) ? $clog2(SB_DEPTH) : 1;
  localparam int CW = $clog2(SB_DEPTH + 1);
  localparam int IW = (LT_DEPTH > 1) ? $clog2(LT_DEPTH) : 1;

  logic [AW-1:0] sb_addr [SB_DEPTH];
  logic [DW-1:0] sb_data [SB_DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] occ, occ_nxt, fenced, fen_nxt;

  logic [LT_DEPTH-1:0] lt_v, lt_sq;
  logic [AW-1:0] lt_addr [LT_DEPTH];
  logic [TW-1:0] lt_tag  [LT_DEPTH];
  logic [CW-1:0] lt_cnt  [LT_DEPTH];

  logic ret_hit, sq_hit, free_hit;
  logic [IW-1:0] ret_idx, sq_idx, free_idx;

  wire push    = st_valid && st_ready;
  wire pop     = mem_valid && mem_ready;
  wire ld_take = ld_valid && !lt_full;

  assign st_ready  = (occ != CW'(SB_DEPTH));
  assign mem_valid = (occ != '0);
  assign drained   = (occ == '0);
  assign mem_addr  = sb_addr[head];
  assign mem_data  = sb_data[head];
  assign lt_full   = &lt_v;
  assign ret_valid = ret_hit;
  assign ret_tag   = lt_tag[ret_idx];
  assign sq_valid  = sq_hit;
  assign sq_tag    = lt_tag[sq_idx];

  assign occ_nxt = occ + CW'(push) - CW'(pop);
  assign fen_nxt = fence_valid ? occ_nxt : fenced - CW'(pop && fenced != '0);

  always_comb begin
    ret_hit = 1'b0; ret_idx = '0;
    sq_hit = 1'b0; sq_idx = '0;
    free_hit = 1'b0; free_idx = '0;
    for (int i = LT_DEPTH - 1; i >= 0; i--) begin
      if (lt_v[i] && !lt_sq[i] && lt_cnt[i] == '0) begin
        ret_hit = 1'b1; ret_idx = IW'(i);
      end
      if (lt_v[i] && lt_sq[i]) begin
        sq_hit = 1'b1; sq_idx = IW'(i);
      end
      if (!lt_v[i]) begin
        free_hit = 1'b1; free_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head   <= '0;
      tail   <= '0;
      occ    <= '0;
      fenced <= '0;
    end else begin
      if (push) tail <= (tail == PW'(SB_DEPTH - 1)) ? '0 : tail + 1'b1;
      if (pop)  head <= (head == PW'(SB_DEPTH - 1)) ? '0 : head + 1'b1;
      occ    <= occ_nxt;
      fenced <= fen_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      sb_addr[tail] <= st_addr;
      sb_data[tail] <= st_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lt_v  <= '0;
      lt_sq <= '0;
      for (int i = 0; i < LT_DEPTH; i++) begin
        lt_addr[i] <= '0;
        lt_tag[i]  <= '0;
        lt_cnt[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < LT_DEPTH; i++) begin
        if (lt_v[i]) begin
          if (inv_valid && lt_addr[i] == inv_addr && lt_cnt[i] != '0) lt_sq[i] <= 1'b1;
          if (pop && lt_cnt[i] != '0) lt_cnt[i] <= lt_cnt[i] - 1'b1;
        end
      end
      if (ret_hit) lt_v[ret_idx] <= 1'b0;
      if (sq_hit) begin
        lt_v[sq_idx]  <= 1'b0;
        lt_sq[sq_idx] <= 1'b0;
      end
      if (ld_take && free_hit) begin
        lt_v[free_idx]    <= 1'b1;
        lt_addr[free_idx] <= ld_addr;
        lt_tag[free_idx]  <= ld_tag;
        lt_cnt[free_idx]  <= fen_nxt;
        lt_sq[free_idx]   <= inv_valid && inv_addr == ld_addr && fen_nxt != '0;
      end
    end
  end
endmodule

// File: rtl/fence_wb_chk.sv
module fence_wb_chk #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int TW = 4,
  parameter int SB_DEPTH = 4,
  parameter int LT_DEPTH = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_valid,
  input logic          st_ready,
  input logic          mem_valid,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_data,
  input logic          mem_ready,
  input logic          ld_valid,
  input logic          lt_full,
  input logic          ret_valid,
  input logic [TW-1:0] ret_tag,
  input logic          sq_valid,
  input logic [TW-1:0] sq_tag,
  input logic          drained
);
  localparam int CW = $clog2(SB_DEPTH + 1);
  localparam int LW = $clog2(LT_DEPTH + 1);

  logic [CW-1:0] s_cnt;
  logic [LW-1:0] l_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cnt <= '0;
      l_cnt <= '0;
    end else begin
      s_cnt <= s_cnt + CW'(st_valid && st_ready) - CW'(mem_valid && mem_ready);
      l_cnt <= l_cnt + LW'(ld_valid && !lt_full) - LW'(ret_valid) - LW'(sq_valid);
    end
  end

  assert_hold_offer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  assert_ready_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_ready == (s_cnt != CW'(SB_DEPTH)));

  assert_drained_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drained == (s_cnt == '0));

  assert_table_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lt_full == (l_cnt == LW'(LT_DEPTH)));

  assert_distinct_tags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && sq_valid |-> ret_tag != sq_tag);
endmodule

bind fence_wb_ctrl fence_wb_chk #(
  .AW(AW), .DW(DW), .TW(TW), .SB_DEPTH(SB_DEPTH), .LT_DEPTH(LT_DEPTH)
) i_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
  .mem_ready(mem_ready), .ld_valid(ld_valid), .lt_full(lt_full),
  .ret_valid(ret_valid), .ret_tag(ret_tag), .sq_valid(sq_valid),
  .sq_tag(sq_tag), .drained(drained)
);

// File: tb/test_fence_wb_ctrl.sv
module test_fence_wb_ctrl;
  localparam int AW = 16, DW = 32, TW = 4, SB = 4, LT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 0, mem_ready = 0, fence_valid = 0, ld_valid = 0, inv_valid = 0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0, inv_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [TW-1:0] ld_tag = '0;
  logic st_ready, mem_valid, lt_full, ret_valid, sq_valid, drained;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic [TW-1:0] ret_tag, sq_tag;

  int checks = 0, errors = 0, ntag = 0, fen = 0;
  logic [AW-1:0] qa[$];
  logic [DW-1:0] qd[$];
  int mt[$], ma[$], mc[$];
  bit ms[$];

  always #10 clk = ~clk;

  fence_wb_ctrl #(.AW(AW), .DW(DW), .TW(TW), .SB_DEPTH(SB), .LT_DEPTH(LT)) i_fence_wb_ctrl (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .st_ready(st_ready), .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ready(mem_ready), .fence_valid(fence_valid), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_tag(ld_tag), .lt_full(lt_full), .inv_valid(inv_valid), .inv_addr(inv_addr),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .sq_valid(sq_valid), .sq_tag(sq_tag),
    .drained(drained));

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit eret = 0, esq = 0, rin = 0, sin = 0;
    foreach (mt[i]) begin
      if (mc[i] == 0 && !ms[i]) begin
        eret = 1;
        if (mt[i] == int'(ret_tag)) rin = 1;
      end
      if (ms[i]) begin
        esq = 1;
        if (mt[i] == int'(sq_tag)) sin = 1;
      end
    end
    check(mem_valid == (qa.size() > 0), "R2 mem_valid", mem_valid, qa.size() > 0);
    if (mem_valid && qa.size() > 0) begin
      check(mem_addr == qa[0], "R2 mem_addr order", mem_addr, qa[0]);
      check(mem_data == qd[0], "R2 mem_data order", mem_data, qd[0]);
    end
    check(st_ready == (qa.size() < SB), "R3 st_ready", st_ready, qa.size() < SB);
    check(drained == (qa.size() == 0), "R3 drained", drained, qa.size() == 0);
    check(lt_full == (mt.size() == LT), "R8 lt_full", lt_full, mt.size() == LT);
    check(ret_valid == eret, "R5/R6 ret_valid", ret_valid, eret);
    if (ret_valid && eret) check(rin, "R9 ret_tag eligible", ret_tag, 1);
    check(sq_valid == esq, "R7 sq_valid", sq_valid, esq);
    if (sq_valid && esq) check(sin, "R7 sq_tag marked", sq_tag, 1);
  endtask

  task automatic step(bit sv, bit mr, bit fv, bit lv, int la, bit iv, int ia);
    bit pop, push, acc;
    @(negedge clk);
    compare();
    st_valid = sv; st_addr = AW'($urandom); st_data = $urandom;
    mem_ready = mr; fence_valid = fv;
    ld_valid = lv; ld_addr = AW'(la); ld_tag = TW'(ntag);
    inv_valid = iv; inv_addr = AW'(ia);
    pop = qa.size() > 0 && mr;
    push = sv && qa.size() < SB;
    acc = lv && mt.size() < LT;
    if (ret_valid)
      for (int i = 0; i < mt.size(); i++)
        if (mt[i] == int'(ret_tag) && mc[i] == 0 && !ms[i]) begin
          mt.delete(i); ma.delete(i); mc.delete(i); ms.delete(i); break;
        end
    if (sq_valid)
      for (int i = 0; i < mt.size(); i++)
        if (mt[i] == int'(sq_tag) && ms[i]) begin
          mt.delete(i); ma.delete(i); mc.delete(i); ms.delete(i); break;
        end
    foreach (mt[i]) begin
      if (iv && ma[i] == ia && mc[i] != 0) ms[i] = 1;
      if (pop && mc[i] > 0) mc[i]--;
    end
    if (pop) begin void'(qa.pop_front()); void'(qd.pop_front()); end
    if (push) begin qa.push_back(st_addr); qd.push_back(st_data); end
    if (fv) fen = qa.size();
    else if (pop && fen > 0) fen--;
    if (acc) begin
      mt.push_back(ntag); ma.push_back(la); mc.push_back(fen);
      ms.push_back(iv && ia == la && fen != 0);
      ntag = (ntag + 1) % (1 << TW);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!mem_valid && st_ready && drained, "R1 store side reset", {mem_valid, st_ready, drained}, 3'b011);
    check(!ret_valid && !sq_valid && !lt_full, "R1 load side reset", {ret_valid, sq_valid, lt_full}, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0);
    // R5: load with nothing buffered passes at once
    step(0, 0, 0, 1, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    // R4 R6: stores held, fence in the cycle of the fourth store, loads behind it
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 1, 1, 2, 0, 0);
    step(1, 0, 0, 1, 3, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    // R7: invalidation hits the second speculative load
    step(0, 0, 0, 0, 0, 1, 3);
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    // R2 R6: drain, first load retires after the last pre-fence store
    for (int k = 0; k < 6; k++) step(0, 1, 0, 0, 0, 0, 0);
    // R8 R9: fill the load table, several become eligible together
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 1, 1, 0, 0, 0);
    step(0, 0, 0, 1, 1, 0, 0);
    step(0, 0, 0, 1, 2, 0, 0);
    step(0, 0, 0, 1, 0, 1, 0);
    step(0, 0, 0, 1, 3, 0, 0);
    step(0, 0, 0, 0, 0, 1, 1);
    for (int k = 0; k < 8; k++) step(0, 1, 0, 0, 0, 0, 0);
    // R3: fill the store buffer, extra stores are refused
    for (int k = 0; k < 6; k++) step(1, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 6; k++) step(0, 1, 0, 0, 0, 0, 0);
    for (int k = 0; k < 4000; k++)
      step(($urandom % 3) != 0, ($urandom % 3) == 0, ($urandom % 6) == 0,
           ($urandom % 3) == 0, int'($urandom % 4), ($urandom % 5) == 0, int'($urandom % 4));
    for (int k = 0; k < 12; k++) step(0, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule